// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which interrupt a 16550-style serial port reports, and whether its interrupt request line is raised. It holds the 4-bit interrupt enable register and the transmit-holding-empty pending flag. Each cycle it looks at the line status byte and the four modem-status delta bits from the rest of the UART. From these it picks the one source with the highest priority. It registers the matching identification code into the low nibble of the identification register, and drives the request output from that code.

The upper nibble of the identification register carries FIFO state that is produced elsewhere. It is loaded only through its own strobe, so a change of interrupt source never disturbs it. Software reaches the enable register through a write strobe that keeps only the low four bits. A write made while the transmitter is empty raises the holding-empty pending flag, the same way a fresh empty event does.

Top module: `uirq_ident`

## Requirements
- R1: While the stored enable value is zero, `irq_o` is low on the following cycle and the code is none, whatever the sources are doing.
- R2: Source priority, highest first, is: line-status error, received data, holding-empty pending, modem-status change.
- R3: The line-status error source is active only when enable bit 2 is set and any of `lsr` bits 4:1 (mask 0x1E) is set. `lsr` bits 0, 5, 6 and 7 never raise it.
- R4: The received-data source uses `lsr` bit 0, qualified by enable bit 0. The modem source is any of the four `msr_delta` bits, qualified by enable bit 3. The holding-empty source is the pending flag, qualified by enable bit 1.
- R5: The codes in `iir_o[3:0]` are 0x1 for none, 0x6 for line status, 0x4 for received data, 0x2 for holding empty and 0x0 for modem status.
- R6: `iir_o[7:4]` changes only on `iir_hi_wr` (taking `iir_hi_data`) and is kept while the low nibble changes.
- R7: `irq_o` is high exactly when `iir_o[3:0]` is not 0x1.
- R8: An enable write stores only `ier_wdata[3:0]`, which is visible on `ier_o` after one clock edge.
- R9: The pending flag is set by `thre_set`, and by an enable write while `thr_empty` is high. It is cleared by `thre_clr`. When a set and a clear land in the same cycle, the set wins.
- R10: `iir_o` and `irq_o` are registered: they follow a change on `lsr` or `msr_delta` one edge later, and an enable write or pending change two edges after the strobe.
- R11: Reset, synchronous and active high, gives `ier_o`=0, pending=0, `iir_o`=0x01, `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable write data (low nibble kept) |
| lsr | input | 8 | Line status byte |
| msr_delta | input | 4 | Modem status delta bits |
| thr_empty | input | 1 | Transmit holding register currently empty |
| thre_set | input | 1 | Set the holding-empty pending flag |
| thre_clr | input | 1 | Clear the holding-empty pending flag |
| iir_hi_wr | input | 1 | Load strobe for the upper identification nibble |
| iir_hi_data | input | 4 | Upper nibble value |
| ier_o | output | 4 | Stored enable value |
| thre_pend_o | output | 1 | Holding-empty pending flag |
| iir_o | output | 8 | Identification register |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in the same cycle. The first pair is an enable write made while the transmitter is empty and a clear of the pending flag. The bench drives both strobes on the same clock and checks that the flag ends up set. The second pair is several sources active at once. The vector table asserts the error, data, holding-empty and modem sources together in different mixes, and each time judges that only the highest enabled one appears in the code. It also checks that the upper nibble loaded earlier survives these updates.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC   = 4;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    IID_MS   = 4'h0,
    IID_NONE = 4'h1,
    IID_THRE = 4'h2,
    IID_RXD  = 4'h4,
    IID_RLS  = 4'h6
  } iid_e;

  localparam logic [7:0] LSR_ERR_MASK = 8'h1E;

  // source index 0 is the highest priority
  function automatic iid_e src_code(input int idx);
    case (idx)
      0:       return IID_RLS;
      1:       return IID_RXD;
      2:       return IID_THRE;
      default: return IID_MS;
    endcase
  endfunction

  // enable register bit that qualifies each source index
  function automatic int src_en_bit(input int idx);
    case (idx)
      0:       return 2;
      1:       return 0;
      2:       return 1;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/uirq_ier_reg.sv
module uirq_ier_reg #(
  parameter int DATA_W = 8,
  parameter int IER_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ier_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              thr_empty,
  input  logic              thre_set,
  input  logic              thre_clr,
  output logic [IER_W-1:0]  ier_q,
  output logic              thre_pend_q
);
  logic pend_set;
  assign pend_set = thre_set | (ier_wr & thr_empty);

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q       <= '0;
      thre_pend_q <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= wr_data[IER_W-1:0];
      if (pend_set)      thre_pend_q <= 1'b1;
      else if (thre_clr) thre_pend_q <= 1'b0;
    end
  end

  // R8
  ier_low_chk: assert property (@(posedge clk) disable iff (rst)
    ier_wr |=> ier_q == $past(wr_data[IER_W-1:0]));

  // R9
  thre_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ier_wr && thr_empty) |=> thre_pend_q);
endmodule

// File: rtl/uirq_src.sv
module uirq_src
  import uirq_pkg::*;
#(
  parameter int LSR_W = 8,
  parameter int MSD_W = 4
) (
  input  logic [NSRC-1:0]  ier,
  input  logic [LSR_W-1:0] lsr,
  input  logic             thre_pend,
  input  logic [MSD_W-1:0] msr_delta,
  output logic [NSRC-1:0]  req
);
  logic [NSRC-1:0] raw;

  always_comb begin
    raw    = '0;
    raw[0] = |(lsr & LSR_W'(LSR_ERR_MASK));
    raw[1] = lsr[0];
    raw[2] = thre_pend;
    raw[3] = |msr_delta;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_qual
    assign req[i] = raw[i] & ier[src_en_bit(i)];
  end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output iid_e            code,
  output logic [NSRC-1:0] grant
);
  assign grant[0] = req[0];
  for (genvar i = 1; i < NSRC; i++) begin : g_grant
    assign grant[i] = req[i] & ~(|req[i-1:0]);
  end

  always_comb begin
    code = IID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) code = src_code(i);
    end
  end
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
  import uirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LSR_W  = 8,
  parameter int MSD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ier_wr,
  input  logic [DATA_W-1:0] ier_wdata,
  input  logic [LSR_W-1:0]  lsr,
  input  logic [MSD_W-1:0]  msr_delta,
  input  logic              thr_empty,
  input  logic              thre_set,
  input  logic              thre_clr,
  input  logic              iir_hi_wr,
  input  logic [DATA_W-CODE_W-1:0] iir_hi_data,
  output logic [NSRC-1:0]   ier_o,
  output logic              thre_pend_o,
  output logic [DATA_W-1:0] iir_o,
  output logic              irq_o
);
  localparam int HI_W = DATA_W - CODE_W;

  logic [NSRC-1:0]   ier_q;
  logic              pend_q;
  logic [NSRC-1:0]   req;
  logic [NSRC-1:0]   grant;
  iid_e              prio_code;
  iid_e              code_d;
  logic [CODE_W-1:0] iir_lo_q;
  logic [HI_W-1:0]   iir_hi_q;

  uirq_ier_reg #(.DATA_W(DATA_W), .IER_W(NSRC)) u_ier (
    .clk(clk), .rst(rst), .ier_wr(ier_wr), .wr_data(ier_wdata),
    .thr_empty(thr_empty), .thre_set(thre_set), .thre_clr(thre_clr),
    .ier_q(ier_q), .thre_pend_q(pend_q)
  );

  uirq_src #(.LSR_W(LSR_W), .MSD_W(MSD_W)) u_src (
    .ier(ier_q), .lsr(lsr), .thre_pend(pend_q),
    .msr_delta(msr_delta), .req(req)
  );

  uirq_prio u_prio (.req(req), .code(prio_code), .grant(grant));

  // an all-zero enable register forces the none code
  assign code_d = (ier_q == '0) ? IID_NONE : prio_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_lo_q <= IID_NONE;
      iir_hi_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      iir_lo_q <= code_d;
      irq_o    <= (code_d != IID_NONE);
      if (iir_hi_wr) iir_hi_q <= iir_hi_data;
    end
  end

  assign iir_o       = {iir_hi_q, iir_lo_q};
  assign ier_o       = ier_q;
  assign thre_pend_o = pend_q;

  // R7
  irq_code_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (iir_o[CODE_W-1:0] != IID_NONE));

  // R1
  ier_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ier_q == '0) |=> !irq_o);

  // R6
  iir_hi_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !iir_hi_wr |=> $stable(iir_o[DATA_W-1:CODE_W]));

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: tb/uirq_ident_test.sv
module uirq_ident_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 5000;
  localparam int NVEC = 14;
  // fields: enable nibble, lsr byte, delta nibble, thre (1 set / 0 clear), expected code
  localparam logic [23:0] VEC [NVEC] = '{
    24'hF00001, 24'hF01004, 24'hF03006, 24'hF10F16,
    24'hF00012, 24'hF00112, 24'hF00800, 24'h800200,
    24'h700401, 24'h11F004, 24'h0FFF11, 24'h4E0001,
    24'h201012, 24'h51F006
  };

  logic       clk = 0;
  logic       rst = 1;
  logic       ier_wr = 0;
  logic [7:0] ier_wdata = 0;
  logic [7:0] lsr = 0;
  logic [3:0] msr_delta = 0;
  logic       thr_empty = 0, thre_set = 0, thre_clr = 0;
  logic       iir_hi_wr = 0;
  logic [3:0] iir_hi_data = 0;
  logic [3:0] ier_o;
  logic       thre_pend_o;
  logic [7:0] iir_o;
  logic       irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uirq_ident uut (
    .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .lsr(lsr), .msr_delta(msr_delta), .thr_empty(thr_empty),
    .thre_set(thre_set), .thre_clr(thre_clr), .iir_hi_wr(iir_hi_wr),
    .iir_hi_data(iir_hi_data), .ier_o(ier_o), .thre_pend_o(thre_pend_o),
    .iir_o(iir_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 iir", iir_o, 8'h01);
    chk("R11 irq", irq_o, 0);
    chk("R11 ier", ier_o, 0);
    chk("R11 pend", thre_pend_o, 0);

    // R2 R3 R4 R5 R7 vector walk, upper write bits set to test R8
    for (int i = 0; i < NVEC; i++) begin
      ier_wr = 1; ier_wdata = {4'hA, VEC[i][23:20]};
      lsr = VEC[i][19:12]; msr_delta = VEC[i][11:8];
      thre_set = VEC[i][4]; thre_clr = !VEC[i][4];
      @(negedge clk);
      ier_wr = 0; thre_set = 0; thre_clr = 0;
      chk("R8 ier low nibble", ier_o, VEC[i][23:20]);
      @(negedge clk);
      chk("R2/R5 code", iir_o[3:0], VEC[i][3:0]);
      chk("R7 irq", irq_o, VEC[i][3:0] != 4'h1);
    end

    // R6 upper nibble load and keep
    iir_hi_wr = 1; iir_hi_data = 4'hC;
    @(negedge clk);
    iir_hi_wr = 0;
    chk("R6 load", iir_o[7:4], 4'hC);
    ier_wr = 1; ier_wdata = 8'h01; lsr = 8'h00; msr_delta = 0;
    @(negedge clk);
    ier_wr = 0;
    @(negedge clk);
    chk("R6 kept", iir_o, 8'hC1);
    // R10 lsr change reaches iir after one edge
    lsr = 8'h01;
    @(negedge clk);
    chk("R10 one edge", iir_o, 8'hC4);

    // R9 enable write while empty sets pending
    lsr = 0; thre_clr = 1;
    @(negedge clk);
    thre_clr = 0;
    chk("R9 cleared", thre_pend_o, 0);
    ier_wr = 1; ier_wdata = 8'h02; thr_empty = 1;
    @(negedge clk);
    ier_wr = 0; thr_empty = 0;
    chk("R9 write sets pend", thre_pend_o, 1);
    @(negedge clk);
    chk("R9 thre code", iir_o[3:0], 4'h2);
    // R9 set wins over clear in same cycle
    thre_clr = 1;
    @(negedge clk);
    thre_clr = 0;
    chk("R9 clear", thre_pend_o, 0);
    ier_wr = 1; ier_wdata = 8'h02; thr_empty = 1; thre_clr = 1;
    @(negedge clk);
    ier_wr = 0; thr_empty = 0; thre_clr = 0;
    chk("R9 set beats clear", thre_pend_o, 1);

    // R1 zero enable forces irq low, R10 two-edge latency
    ier_wr = 1; ier_wdata = 8'h0F; lsr = 8'h1F; msr_delta = 4'hF;
    @(negedge clk);
    ier_wr = 0;
    @(negedge clk);
    chk("R1 active first", irq_o, 1);
    ier_wr = 1; ier_wdata = 8'hF0;
    @(negedge clk);
    ier_wr = 0;
    chk("R10 still high after one edge", irq_o, 1);
    @(negedge clk);
    chk("R1 irq forced low", irq_o, 0);
    chk("R1 code none", iir_o, 8'hC1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule